// File: doc/BRIEF.md
# LCD Output Data Packer

This block sits between the pixel pipeline (FIFO, palette and dithering stages, none of them part of this block) and the timing generator of an LCD controller. It takes pixel data through ready/valid handshakes and assembles words for a 24-bit parallel panel data bus. Each time a word is complete it raises a one-cycle word strobe.

Three configuration inputs pick the output format. The display type selects TFT, STN monochrome or STN colour. The scan mode selects single or dual panel. On STN the interface width selects 4, 8 or 16 active data bits. TFT passes each 24-bit pixel out whole. STN modes pack 1-bit dithered sub-pixels into the active bits. In dual scan a second input stream supplies the lower panel, and each panel fills its own half of the active width.

Combinations that are not allowed raise a sticky error flag and stop all traffic. Configuration is changed only while the block is disabled. Disabling also discards any partly built word.

Top module: `lcd_data_packer`

## Requirements
- R1: With display type 0 (TFT) and single scan, every accepted pixel `up_data` (R in [23:16], G in [15:8], B in [7:0]) appears unchanged on `out_data`, with `out_valid` high, one clock after acceptance.
- R2: With display type 1 (STN monochrome), each transfer carries one pixel in `up_data[0]`. Pixels fill the active bits from the most significant bit downward, earliest pixel first.
- R3: With display type 2 (STN colour), each transfer carries R, G and B in `up_data[2]`, `up_data[1]` and `up_data[0]`. They are packed in the order R, G, B. A pixel that does not fit the rest of a word continues at the top of the next word.
- R4: In dual scan (`cfg_dual`=1) the upper-panel stream fills the lower half of the active bits and the lower-panel stream (`lo_data`, same bit layout) fills the upper half. The two streams are accepted only together, in the same cycle. In single scan `lo_ready` stays low.
- R5: Width codes are 0 = 4 bits, 1 = 8 bits and 2 = 16 bits. Enabling the block with an illegal combination sets `cfg_err` on the next clock. The illegal combinations are TFT with dual scan, 4 bits with dual scan, 16 bits with single scan, display type 3, and STN with width code 3.
- R6: While the configuration is illegal or `cfg_err` is set, both ready outputs stay low and no word is produced.
- R7: `cfg_err` stays set while `enable` stays high, and clears on the clock after `enable` is low.
- R8: In STN modes the bits of `out_data` above the active width are zero.
- R9: Deasserting `enable` discards any partly filled word. After re-enabling, the first word holds only newly accepted data.
- R10: After reset `out_valid`, `out_data`, `cfg_err` and both ready outputs are zero.
- R11: While `enable` is low, both ready outputs are low and `out_valid` is low on the next clock. `out_valid` pulses for exactly one clock per completed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; low clears partial words and the error flag |
| cfg_dtype | input | 2 | Display type: 0 TFT, 1 STN monochrome, 2 STN colour |
| cfg_dual | input | 1 | 0 single scan, 1 dual scan |
| cfg_width | input | 2 | STN width: 0 = 4 bits, 1 = 8 bits, 2 = 16 bits |
| up_valid | input | 1 | Upper-panel (or only) stream valid |
| up_ready | output | 1 | Upper-panel stream ready |
| up_data | input | 24 | Upper-panel pixel data |
| lo_valid | input | 1 | Lower-panel stream valid (dual scan) |
| lo_ready | output | 1 | Lower-panel stream ready |
| lo_data | input | 3 | Lower-panel sub-pixels (R in [2], G in [1], B in [0]; mono in [0]) |
| out_data | output | 24 | Packed panel data word |
| out_valid | output | 1 | One-cycle strobe: new word on `out_data` |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The bound assertions check properties that must hold on every clock: TFT pass-through, lockstep acceptance of the two panel streams, setting and holding of the error flag, silence while the error flag is set, zero bits above the active width, and the quiet state while disabled. Whether bits land in the correct order, whether a colour pixel is split correctly across two words, and how each dual-scan half is placed can only be shown by the bench's reference model. That model builds each word from bit queues and compares it with the design on every clock. The bench's scenarios also cover the discarding of a partial word on disable.

// File: rtl/lcd_pack_pkg.sv
package lcd_pack_pkg;

   typedef enum logic [1:0] {
      DISP_TFT       = 2'd0,
      DISP_STN_MONO  = 2'd1,
      DISP_STN_COLOR = 2'd2,
      DISP_RSVD      = 2'd3
   } disp_e;

   typedef enum logic [1:0] {
      BUS_4    = 2'd0,
      BUS_8    = 2'd1,
      BUS_16   = 2'd2,
      BUS_RSVD = 2'd3
   } bus_e;

   // Configuration combinations the packer refuses to run.
   function automatic logic cfg_illegal(input disp_e dt, input logic dual, input bus_e bw);
      logic bad;
      bad = 1'b0;
      if (dt == DISP_RSVD)                 bad = 1'b1;
      if (dt == DISP_TFT && dual)          bad = 1'b1;
      if (dt != DISP_TFT) begin
         if (bw == BUS_RSVD)               bad = 1'b1;
         if (bw == BUS_4 && dual)          bad = 1'b1;
         if (bw == BUS_16 && !dual)        bad = 1'b1;
      end
      return bad;
   endfunction

endpackage

// File: rtl/lcd_cfg_check.sv
module lcd_cfg_check
   import lcd_pack_pkg::*;
#(
   parameter int CNTW = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic [1:0]      dtype,
   input  logic            dual,
   input  logic [1:0]      width,
   output logic            illegal,
   output logic            err,
   output logic            is_tft,
   output logic [1:0]      bits_per_xfer,
   output logic [CNTW-1:0] half_w
);

   logic [CNTW-1:0] full_w;

   always_comb begin
      illegal = cfg_illegal(disp_e'(dtype), dual, bus_e'(width));
      is_tft  = (disp_e'(dtype) == DISP_TFT);
      bits_per_xfer = (disp_e'(dtype) == DISP_STN_MONO) ? 2'd1 : 2'd3;
      case (bus_e'(width))
         BUS_4:   full_w = CNTW'(4);
         BUS_8:   full_w = CNTW'(8);
         default: full_w = CNTW'(16);
      endcase
      half_w = dual ? (full_w >> 1) : full_w;
   end

   // Sticky while enabled; the disabled window is where reconfiguration happens.
   always_ff @(posedge clk) begin
      if (!rst_n)       err <= 1'b0;
      else if (!enable) err <= 1'b0;
      else              err <= err | illegal;
   end

endmodule

// File: rtl/lcd_bit_accum.sv
module lcd_bit_accum #(
   parameter int MAXW = 16,
   localparam int BW   = MAXW + 2,
   localparam int CNTW = $clog2(BW + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            push,
   input  logic [1:0]      nbits,
   input  logic [2:0]      bits,
   input  logic [CNTW-1:0] hw,
   output logic            full,
   output logic [MAXW-1:0] word
);

   // Pending bits are kept left-aligned: the oldest bit sits at BW-1.
   logic [BW-1:0]   pbuf, ext, nbuf, rem;
   logic [CNTW-1:0] cnt, ncnt, shamt;
   logic [2:0]      masked;

   always_comb begin
      masked = (nbits == 2'd1) ? {2'b00, bits[0]} : bits;
      shamt  = CNTW'(BW) - cnt - CNTW'(nbits);
      ext    = BW'(masked) << shamt;
      nbuf   = pbuf | ext;
      ncnt   = cnt + CNTW'(nbits);
      full   = push && (ncnt >= hw);
      word   = MAXW'(nbuf >> (CNTW'(BW) - hw));
      rem    = nbuf << hw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         pbuf <= '0;
         cnt  <= '0;
      end else if (push) begin
         if (full) begin
            pbuf <= rem;
            cnt  <= ncnt - hw;
         end else begin
            pbuf <= nbuf;
            cnt  <= ncnt;
         end
      end
   end

endmodule

// File: rtl/lcd_data_packer.sv
module lcd_data_packer #(
   parameter int DW     = 24,
   parameter int CDEPTH = 8,
   parameter int MAXW   = 16,
   parameter int LANES  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [1:0]    cfg_dtype,
   input  logic          cfg_dual,
   input  logic [1:0]    cfg_width,
   input  logic          up_valid,
   output logic          up_ready,
   input  logic [DW-1:0] up_data,
   input  logic          lo_valid,
   output logic          lo_ready,
   input  logic [2:0]    lo_data,
   output logic [DW-1:0] out_data,
   output logic          out_valid,
   output logic          cfg_err
);

   localparam int BW   = MAXW + 2;
   localparam int CNTW = $clog2(BW + 1);

   if (DW != 3 * CDEPTH) begin : g_bad_dw
      $error("packer: bus width must hold three colour channels");
   end
   if (MAXW != 16 || MAXW > DW) begin : g_bad_maxw
      $error("packer: STN width limit must be 16 and fit the bus");
   end
   if (LANES != 2) begin : g_bad_lanes
      $error("packer: exactly two panel lanes are supported");
   end

   logic            illegal, is_tft;
   logic [1:0]      nbits;
   logic [CNTW-1:0] hw;
   logic            go, fire, word_done;
   logic [DW-1:0]   stn_word;
   logic [2:0]      lane_bits [LANES];
   logic            lane_push [LANES];
   logic            lane_full [LANES];
   logic [MAXW-1:0] lane_word [LANES];

   lcd_cfg_check #(.CNTW(CNTW)) i_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .dtype        (cfg_dtype),
      .dual         (cfg_dual),
      .width        (cfg_width),
      .illegal      (illegal),
      .err          (cfg_err),
      .is_tft       (is_tft),
      .bits_per_xfer(nbits),
      .half_w       (hw)
   );

   assign go       = enable && !illegal && !cfg_err;
   assign up_ready = go && (!cfg_dual || lo_valid);
   assign lo_ready = go && cfg_dual && up_valid;
   assign fire     = go && up_valid && (!cfg_dual || lo_valid);

   assign lane_bits[0] = up_data[2:0];
   assign lane_bits[1] = lo_data;
   assign lane_push[0] = fire && !is_tft;
   assign lane_push[1] = fire && !is_tft && cfg_dual;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      lcd_bit_accum #(.MAXW(MAXW)) i_acc (
         .clk  (clk),
         .rst_n(rst_n),
         .clear(!enable),
         .push (lane_push[g]),
         .nbits(nbits),
         .bits (lane_bits[g]),
         .hw   (hw),
         .full (lane_full[g]),
         .word (lane_word[g])
      );
   end

   // Upper panel in the low half, lower panel shifted above it.
   always_comb begin
      stn_word = DW'(lane_word[0]);
      if (cfg_dual) stn_word = stn_word | (DW'(lane_word[1]) << hw);
   end

   assign word_done = fire && (is_tft || lane_full[0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= word_done;
         if (word_done) out_data <= is_tft ? up_data : stn_word;
      end
   end

endmodule

// File: rtl/lcd_data_packer_chk.sv
module lcd_data_packer_chk
   import lcd_pack_pkg::*;
#(
   parameter int DW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          enable,
   input logic [1:0]    cfg_dtype,
   input logic          cfg_dual,
   input logic [1:0]    cfg_width,
   input logic          up_valid,
   input logic          up_ready,
   input logic [DW-1:0] up_data,
   input logic          lo_valid,
   input logic          lo_ready,
   input logic [DW-1:0] out_data,
   input logic          out_valid,
   input logic          cfg_err
);

   logic bad_cfg;
   logic stn;
   logic [DW-1:0] above;
   assign bad_cfg = cfg_illegal(disp_e'(cfg_dtype), cfg_dual, bus_e'(cfg_width));
   assign stn     = (cfg_dtype == 2'd1) || (cfg_dtype == 2'd2);
   assign above   = out_data >> (32'd4 << cfg_width);

   a_r1_tft_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dtype == 2'd0 && up_valid && up_ready) |=> (out_valid && out_data == $past(up_data)));

   a_r4_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dual && up_valid && up_ready) |-> (lo_valid && lo_ready));

   a_r4_single_no_lo: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_dual |-> !lo_ready);

   a_r5_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && bad_cfg) |=> cfg_err);

   a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!up_ready && !lo_ready && !out_valid));

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cfg_err) |=> cfg_err);

   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !cfg_err);

   a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && stn) |-> (above == '0));

   a_r11_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!up_ready && !lo_ready));

   a_r11_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !out_valid);

endmodule

bind lcd_data_packer lcd_data_packer_chk #(.DW(DW)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .cfg_dtype(cfg_dtype),
   .cfg_dual (cfg_dual),
   .cfg_width(cfg_width),
   .up_valid (up_valid),
   .up_ready (up_ready),
   .up_data  (up_data),
   .lo_valid (lo_valid),
   .lo_ready (lo_ready),
   .out_data (out_data),
   .out_valid(out_valid),
   .cfg_err  (cfg_err)
);

// File: tb/test_lcd_data_packer.sv
`timescale 1ns/1ps
module test_lcd_data_packer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [1:0]  cfg_dtype = 2'd0;
   logic        cfg_dual = 1'b0;
   logic [1:0]  cfg_width = 2'd1;
   logic        up_valid = 1'b0;
   logic        up_ready;
   logic [23:0] up_data = '0;
   logic        lo_valid = 1'b0;
   logic        lo_ready;
   logic [2:0]  lo_data = '0;
   logic [23:0] out_data;
   logic        out_valid;
   logic        cfg_err;

   always #10 clk = ~clk;

   lcd_data_packer i_lcd_data_packer (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .cfg_dtype(cfg_dtype), .cfg_dual(cfg_dual), .cfg_width(cfg_width),
      .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
      .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_data(lo_data),
      .out_data(out_data), .out_valid(out_valid), .cfg_err(cfg_err)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   bit run_cmp = 0;
   string tag = "R10";
   int unsigned seed = 32'h1234_5678;

   // Reference model state
   bit          q_up[$];
   bit          q_lo[$];
   bit          m_valid;
   logic [23:0] m_data;
   bit          m_err;

   function automatic bit illegal_cfg(input int dt, input bit dual, input int w);
      if (dt == 3) return 1;
      if (dt == 0) return dual;
      if (w == 3) return 1;
      if (w == 0 && dual) return 1;
      if (w == 2 && !dual) return 1;
      return 0;
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 0; m_data = '0; m_err = 0;
         q_up.delete(); q_lo.delete();
      end else begin
         m_valid = 0;
         if (!enable) begin
            q_up.delete(); q_lo.delete();
            m_err = 0;
         end else if (m_err || illegal_cfg(cfg_dtype, cfg_dual, cfg_width)) begin
            m_err = 1;
         end else if (up_valid && (!cfg_dual || lo_valid)) begin
            if (cfg_dtype == 2'd0) begin
               m_valid = 1;
               m_data  = up_data;
            end else begin
               int w;
               int h;
               w = 4 << cfg_width;
               h = cfg_dual ? w / 2 : w;
               if (cfg_dtype == 2'd1) begin
                  q_up.push_back(up_data[0]);
                  if (cfg_dual) q_lo.push_back(lo_data[0]);
               end else begin
                  for (int b = 2; b >= 0; b--) begin
                     q_up.push_back(up_data[b]);
                     if (cfg_dual) q_lo.push_back(lo_data[b]);
                  end
               end
               if (q_up.size() >= h) begin
                  logic [23:0] wd;
                  wd = '0;
                  for (int b = 0; b < h; b++) wd[h-1-b] = q_up.pop_front();
                  if (cfg_dual)
                     for (int b = 0; b < h; b++) wd[w-1-b] = q_lo.pop_front();
                  m_valid = 1;
                  m_data  = wd;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (run_cmp && rst_n) begin
         check(tag, "out_valid", 32'(out_valid), 32'(m_valid));
         check(tag, "out_data", 32'(out_data), 32'(m_data));
         check(tag, "cfg_err", 32'(cfg_err), 32'(m_err));
      end
   end

   function automatic int unsigned next_rand(input int unsigned s);
      return s * 32'd1103515245 + 32'd12345;
   endfunction

   task automatic configure(input int dt, input bit dual, input int w);
      @(negedge clk);
      up_valid = 0; lo_valid = 0;
      enable = 0;
      repeat (2) @(negedge clk);
      cfg_dtype = 2'(dt); cfg_dual = dual; cfg_width = 2'(w);
      @(negedge clk);
      enable = 1;
   endtask

   task automatic send(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         seed = next_rand(seed);
         up_data  = seed[31:8];
         lo_data  = seed[6:4];
         up_valid = 1;
         lo_valid = cfg_dual;
         if (i % 4 == 3) begin
            @(negedge clk);
            up_valid = 0; lo_valid = 0;
         end
      end
      @(negedge clk);
      up_valid = 0; lo_valid = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic illegal_case(input int dt, input bit dual, input int w);
      configure(dt, dual, w);
      up_valid = 1; lo_valid = dual;
      @(negedge clk);
      #1;
      check("R5", "cfg_err after illegal enable", 32'(cfg_err), 32'd1);
      check("R6", "up_ready in error", 32'(up_ready), 32'd0);
      check("R6", "lo_ready in error", 32'(lo_ready), 32'd0);
      repeat (4) @(negedge clk);
      #1;
      check("R7", "cfg_err sticky", 32'(cfg_err), 32'd1);
      up_valid = 0; lo_valid = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      #1;
      check("R10", "out_valid after reset", 32'(out_valid), 32'd0);
      check("R10", "out_data after reset", 32'(out_data), 32'd0);
      check("R10", "cfg_err after reset", 32'(cfg_err), 32'd0);
      check("R11", "up_ready while disabled", 32'(up_ready), 32'd0);
      check("R11", "lo_ready while disabled", 32'(lo_ready), 32'd0);
      run_cmp = 1;

      tag = "R1"; configure(0, 0, 1); send(10);
      tag = "R2/R8"; configure(1, 0, 1); send(24);
      tag = "R3/R8"; configure(2, 0, 0); send(16);
      tag = "R3/R8"; configure(2, 0, 1); send(16);
      tag = "R4/R8"; configure(2, 1, 2); send(16);
      tag = "R4/R8"; configure(1, 1, 1); send(16);
      tag = "R4/R2"; configure(1, 1, 2); send(24);
      tag = "R4/R3"; configure(2, 1, 1); send(12);

      tag = "R9"; configure(2, 0, 1); send(2);
      @(negedge clk); enable = 0;
      repeat (2) @(negedge clk); enable = 1;
      send(8);

      tag = "R5/R6"; illegal_case(0, 1, 1);
      tag = "R5/R6"; illegal_case(1, 1, 0);
      tag = "R5/R6"; illegal_case(2, 0, 2);
      tag = "R5/R6"; illegal_case(3, 0, 1);
      @(negedge clk); enable = 0;
      @(negedge clk);
      #1;
      check("R7", "cfg_err cleared by disable", 32'(cfg_err), 32'd0);

      tag = "R11"; configure(2, 0, 1); send(8);
      repeat (3) @(negedge clk);
      run_cmp = 0;
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule